// File: doc/BRIEF.md
# Four-Stage 16-bit Harvard Processor Core

This block is a compact 16-bit processor core for control and sequencing work. Instructions come from one memory and data lives in another, so an instruction fetch and a data access can happen in the same cycle. Each instruction passes through four stages: fetch, decode with register read, execute (the ALU and the data memory access share this stage), and register writeback. The core has eight 16-bit general registers and a three-bit flag register holding zero, carry and parity.

Both memories are read combinationally by the surrounding logic: the core presents an address and expects the word back in the same cycle. Data memory writes take effect at the clock edge that ends the store's execute cycle. A result produced in execute is forwarded straight to the instruction behind it. Flags produced in execute are also forwarded, so a branch sitting in decode sees them at once. Branches and jumps resolve in decode, which means a taken transfer discards exactly one fetched instruction. A load followed directly by an instruction that reads the loaded register costs one bubble.

Top module: `cpu16_core`

## Requirements
- R1: While `rstN` is low and at the first cycle after it rises, `imemAddr` is 0 and `dmemWe` is 0. All eight registers and all flags reset to 0.
- R2: With no stall and no taken transfer, `imemAddr` increases by exactly one word per clock cycle.
- R3: Instruction words are 16 bits. The opcode is in [15:12], rd in [11:9], rs in [8:6], rt in [5:3], and the 8-bit immediate or offset in [7:0]. Opcode 0 ADD writes rd=rs+rt. Opcode 1 SUB writes rd=rs-rt. Opcodes 2, 3 and 4 write rs AND, OR and XOR rt. Opcode 5 MOV writes rd=sign-extended imm8. Opcode 6 SHL writes rd=rs<<1 and opcode 7 SHR writes rd=rs>>1, both shifting in a 0 and ignoring rt. Opcodes D to F do nothing.
- R4: Every opcode 0 to 4, 6 and 7 sets the zero flag when its 16-bit result is 0. The same opcodes set the parity flag to the XOR of all result bits, which is the bit that gives the word even parity. MOV, loads, stores and branches leave the flags unchanged.
- R5: Carry is bit 16 of the sum for ADD. For SUB it is the borrow, 1 when rs < rt unsigned. For SHL it is the old bit 15 and for SHR the old bit 0. AND, OR and XOR leave carry unchanged.
- R6: Opcode 8 LD writes rd with the data word at address R[rs]. Opcode 9 ST writes R[rd] to address R[rs]. `dmemWe` is high only during a store's execute cycle.
- R7: Opcode A branches when the flag chosen by [10:9] is 1, and opcode B branches when that flag is 0. The selector values are 00 zero, 01 carry and 10 parity. Opcode C always jumps. In every case the target is the transfer's own address plus the sign-extended imm8, so negative offsets go backward.
- R8: A taken branch or jump discards exactly the one instruction fetched behind it. That instruction changes no register and no memory, and execution continues at the target.
- R9: A register result from an ALU or MOV instruction is usable by the very next instruction without a stall. Flags from a data operation are visible to a branch that directly follows it.
- R10: An instruction that reads, as rs, rt or store data, the register loaded by the directly preceding LD is held for one cycle. It then gets the loaded value. During the held cycle `imemAddr` does not change and a bubble enters execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | ADDR_W | Word address of the instruction being fetched |
| imemData | input | 16 | Instruction word at `imemAddr`, same cycle |
| dmemAddr | output | ADDR_W | Data word address of the load or store in execute |
| dmemWrData | output | DATA_W | Store data |
| dmemWe | output | 1 | Data memory write strobe |
| dmemRdData | input | DATA_W | Data word at `dmemAddr`, same cycle |

## Verification
The assertions check the pipeline control on every cycle. The fetch address must step by one unless the core is held or redirected. A hold must freeze the fetch address and must put a bubble into execute. A taken transfer must leave decode empty on the next cycle. The fetch address must start at zero after reset. Only the bench's programs can show that values are correct. This covers ALU results and the value of each flag, which a program exposes by steering branches on it and storing registers. It also covers the values that reach a dependent instruction through forwarding or after a load hold, and the fact that a discarded instruction really leaves no trace.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int REG_AW  = 3;
  localparam int REG_N   = 1 << REG_AW;
  localparam int IMM_W   = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'h0, OP_SUB = 4'h1, OP_AND = 4'h2, OP_OR  = 4'h3,
    OP_XOR = 4'h4, OP_MOV = 4'h5, OP_SHL = 4'h6, OP_SHR = 4'h7,
    OP_LD  = 4'h8, OP_ST  = 4'h9, OP_BEQ = 4'hA, OP_BNE = 4'hB,
    OP_JMP = 4'hC
  } opcodeE;

  // low three opcode bits of the data operations map one to one
  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASS, ALU_SHL, ALU_SHR
  } aluOpE;

  typedef struct packed {
    logic z;
    logic c;
    logic p;
  } flagsT;

  typedef struct packed {
    logic  stall;
    logic  redirect;
    logic  regWrite;
    logic  memLoad;
    logic  memStore;
    logic  useImm;
    logic  flagWrite;
    logic  bFromRd;
    aluOpE aluOp;
  } ctrlT;
endpackage

// File: rtl/cpu16_ctrl.sv
module cpu16_ctrl
  import cpu16_pkg::*;
(
  input  logic [INSTR_W-1:3] idHi,
  input  logic               idValid,
  input  logic               exValid,
  input  logic               exLoad,
  input  logic [REG_AW-1:0]  exRd,
  input  flagsT              flagsFwd,
  output ctrlT               ctrl
);
  logic [REG_AW-1:0] rdIdx, rsIdx, rtIdx;
  logic useRs, useRt, useRd, taken, condFlag;

  assign rdIdx = idHi[11:9];
  assign rsIdx = idHi[8:6];
  assign rtIdx = idHi[5:3];

  always_comb begin
    case (idHi[10:9])
      2'b01:   condFlag = flagsFwd.c;
      2'b10:   condFlag = flagsFwd.p;
      default: condFlag = flagsFwd.z;
    endcase
  end

  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = aluOpE'(idHi[14:12]);
    useRs = 1'b0;
    useRt = 1'b0;
    useRd = 1'b0;
    taken = 1'b0;
    case (idHi[15:12])
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
        ctrl.regWrite = 1'b1; ctrl.flagWrite = 1'b1; useRs = 1'b1; useRt = 1'b1;
      end
      OP_SHL, OP_SHR: begin
        ctrl.regWrite = 1'b1; ctrl.flagWrite = 1'b1; useRs = 1'b1;
      end
      OP_MOV: begin
        ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1;
      end
      OP_LD: begin
        ctrl.regWrite = 1'b1; ctrl.memLoad = 1'b1; useRs = 1'b1;
      end
      OP_ST: begin
        ctrl.memStore = 1'b1; ctrl.bFromRd = 1'b1; useRs = 1'b1; useRd = 1'b1;
      end
      OP_BEQ:  taken = condFlag;
      OP_BNE:  taken = !condFlag;
      OP_JMP:  taken = 1'b1;
      default: ;
    endcase
    if (!idValid) begin
      ctrl.regWrite  = 1'b0;
      ctrl.flagWrite = 1'b0;
      ctrl.memLoad   = 1'b0;
      ctrl.memStore  = 1'b0;
      useRs = 1'b0; useRt = 1'b0; useRd = 1'b0; taken = 1'b0;
    end
    ctrl.redirect = taken;
    ctrl.stall = exValid && exLoad &&
                 ((useRs && rsIdx == exRd) || (useRt && rtIdx == exRd) ||
                  (useRd && rdIdx == exRd));
  end
endmodule

// File: rtl/cpu16_dpath.sv
module cpu16_dpath
  import cpu16_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlT               ctrl,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [ADDR_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWrData,
  output logic               dmemWe,
  input  logic [DATA_W-1:0]  dmemRdData,
  output logic [INSTR_W-1:3] idHi,
  output logic               idValid,
  output logic               exValid,
  output logic               exLoad,
  output logic [REG_AW-1:0]  exRd,
  output flagsT              flagsFwd
);
  logic [ADDR_W-1:0]  pc, idPc, target;
  logic [INSTR_W-1:0] idInstr;
  logic [DATA_W-1:0]  regFile [REG_N];
  logic [DATA_W-1:0]  exA, exB, aluRes, immExt, wbData;
  logic               exRegWrite, exStore, exFlagWrite, wbWe;
  aluOpE              exAluOp;
  logic [REG_AW-1:0]  wbRd;
  logic [DATA_W:0]    sum, diff;
  logic               carry;
  flagsT              flagReg, aluFlags;
  logic [REG_AW-1:0]  srcIdx [2];
  logic [DATA_W-1:0]  srcVal [2];

  assign imemAddr   = pc;
  assign idHi       = idInstr[INSTR_W-1:3];
  assign immExt     = {{(DATA_W-IMM_W){idInstr[IMM_W-1]}}, idInstr[IMM_W-1:0]};
  assign target     = idPc + {{(ADDR_W-IMM_W){idInstr[IMM_W-1]}}, idInstr[IMM_W-1:0]};
  assign srcIdx[0]  = idInstr[8:6];
  assign srcIdx[1]  = ctrl.bFromRd ? idInstr[11:9] : idInstr[5:3];
  assign dmemAddr   = exA[ADDR_W-1:0];
  assign dmemWrData = exB;
  assign dmemWe     = exValid && exStore;

  // operand read with bypass from execute and writeback
  for (genvar k = 0; k < 2; k++) begin : g_src
    always_comb begin
      if (exValid && exRegWrite && !exLoad && exRd == srcIdx[k]) srcVal[k] = aluRes;
      else if (wbWe && wbRd == srcIdx[k])                       srcVal[k] = wbData;
      else                                                      srcVal[k] = regFile[srcIdx[k]];
    end
  end

  always_comb begin
    sum   = {1'b0, exA} + {1'b0, exB};
    diff  = {1'b0, exA} - {1'b0, exB};
    carry = flagReg.c;
    case (exAluOp)
      ALU_ADD: begin aluRes = sum[DATA_W-1:0];  carry = sum[DATA_W];  end
      ALU_SUB: begin aluRes = diff[DATA_W-1:0]; carry = diff[DATA_W]; end
      ALU_AND:  aluRes = exA & exB;
      ALU_OR:   aluRes = exA | exB;
      ALU_XOR:  aluRes = exA ^ exB;
      ALU_PASS: aluRes = exB;
      ALU_SHL: begin aluRes = exA << 1; carry = exA[DATA_W-1]; end
      default: begin aluRes = exA >> 1; carry = exA[0];        end
    endcase
    aluFlags.z = (aluRes == '0);
    aluFlags.c = carry;
    aluFlags.p = ^aluRes;
    flagsFwd   = (exValid && exFlagWrite) ? aluFlags : flagReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0; idPc <= '0; idInstr <= '0; idValid <= 1'b0;
      exValid <= 1'b0; exRegWrite <= 1'b0; exLoad <= 1'b0; exStore <= 1'b0;
      exFlagWrite <= 1'b0; exAluOp <= ALU_ADD; exRd <= '0; exA <= '0; exB <= '0;
      wbWe <= 1'b0; wbRd <= '0; wbData <= '0; flagReg <= '0;
      for (int r = 0; r < REG_N; r++) regFile[r] <= '0;
    end else begin
      // fetch
      if (ctrl.redirect) begin
        pc      <= target;
        idValid <= 1'b0;
      end else if (!ctrl.stall) begin
        pc      <= pc + 1'b1;
        idInstr <= imemData;
        idPc    <= pc;
        idValid <= 1'b1;
      end
      // decode to execute, bubble on hold
      exValid     <= idValid && !ctrl.stall;
      exRegWrite  <= ctrl.regWrite;
      exLoad      <= ctrl.memLoad;
      exStore     <= ctrl.memStore;
      exFlagWrite <= ctrl.flagWrite;
      exAluOp     <= ctrl.aluOp;
      exRd        <= idInstr[11:9];
      exA         <= srcVal[0];
      exB         <= ctrl.useImm ? immExt : srcVal[1];
      // execute to writeback
      wbWe   <= exValid && exRegWrite;
      wbRd   <= exRd;
      wbData <= exLoad ? dmemRdData : aluRes;
      if (exValid && exFlagWrite) flagReg <= aluFlags;
      if (wbWe) regFile[wbRd] <= wbData;
    end
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [ADDR_W-1:0]  dmemAddr,
  output logic [DATA_W-1:0]  dmemWrData,
  output logic               dmemWe,
  input  logic [DATA_W-1:0]  dmemRdData
);
  ctrlT               ctrl;
  flagsT              flagsFwd;
  logic [INSTR_W-1:3] idHi;
  logic               idValid, exValid, exLoad;
  logic [REG_AW-1:0]  exRd;

  cpu16_ctrl u_ctrl (
    .idHi(idHi), .idValid(idValid), .exValid(exValid), .exLoad(exLoad),
    .exRd(exRd), .flagsFwd(flagsFwd), .ctrl(ctrl)
  );

  cpu16_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe),
    .dmemRdData(dmemRdData),
    .idHi(idHi), .idValid(idValid), .exValid(exValid), .exLoad(exLoad),
    .exRd(exRd), .flagsFwd(flagsFwd)
  );
endmodule

// File: rtl/cpu16_chk.sv
module cpu16_chk
  import cpu16_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] imemAddr,
  input ctrlT              ctrl,
  input logic              idValid,
  input logic              exValid
);
  a_r1_fetch_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> imemAddr == '0);

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.stall && !ctrl.redirect) |=> imemAddr == $past(imemAddr) + ADDR_W'(1));

  a_r8_one_discard: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.redirect |=> !idValid);

  a_r10_hold_fetch: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stall |=> $stable(imemAddr));

  a_r10_bubble: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.stall |=> !exValid);
endmodule

bind cpu16_core cpu16_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .ctrl(ctrl),
  .idValid(idValid), .exValid(exValid)
);

// File: tb/cpu16_core_tb.sv
`timescale 1ns/1ps
module cpu16_core_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] imemAddr, imemData, dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWe;
  logic [15:0] imem [64];
  logic [15:0] dmem [64];
  logic        tbWe = 1'b0;
  logic [5:0]  tbAddr = '0;
  logic [15:0] tbData = '0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cpu16_core u_dut (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe),
    .dmemRdData(dmemRdData)
  );

  assign imemData   = imem[imemAddr[5:0]];
  assign dmemRdData = dmem[dmemAddr[5:0]];

  always @(posedge clk) begin
    if (tbWe)        dmem[tbAddr] <= tbData;
    else if (dmemWe) dmem[dmemAddr[5:0]] <= dmemWrData;
  end

  // R3 field layout: op[15:12] rd[11:9] rs[8:6] rt[5:3]; imm8 in [7:0]
  function automatic logic [15:0] rr(input logic [3:0] op, input logic [2:0] rd,
                                     input logic [2:0] rs, input logic [2:0] rt);
    return {op, rd, rs, rt, 3'b000};
  endfunction
  // R7 branch selector sits in [10:9]: 0 zero, 1 carry, 2 parity
  function automatic logic [15:0] ri(input logic [3:0] op, input logic [2:0] rd,
                                     input logic [7:0] imm);
    return {op, rd, 1'b0, imm};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearImem();
    for (int i = 0; i < 64; i++) imem[i] = 16'hF000;
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk); tbWe = 1'b1; tbAddr = 6'(a); tbData = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  task automatic holdReset();
    @(negedge clk); rstN = 1'b0;
  endtask

  task automatic release_();
    @(negedge clk); rstN = 1'b1;
  endtask

  // op(4) a(16) b(16) result(16) z c p
  localparam logic [54:0] VEC [9] = '{
    {4'h0, 16'h7FFF, 16'h0001, 16'h8000, 3'b001},
    {4'h0, 16'hFFFF, 16'h0001, 16'h0000, 3'b110},
    {4'h1, 16'h0003, 16'h0005, 16'hFFFE, 3'b011},
    {4'h1, 16'h1234, 16'h1234, 16'h0000, 3'b100},
    {4'h2, 16'hF0F0, 16'h3C3C, 16'h3030, 3'b000},
    {4'h3, 16'h0F00, 16'h00F1, 16'h0FF1, 3'b001},
    {4'h4, 16'hAAAA, 16'hAAAA, 16'h0000, 3'b100},
    {4'h6, 16'h8001, 16'h0000, 16'h0002, 3'b011},
    {4'h7, 16'h0001, 16'h0000, 16'h0000, 3'b110}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clearImem();
    for (int i = 0; i < 64; i++) dmem[i] = '0;

    // ---- R1 / R2: reset state and straight-line fetch (counting loop program) ----
    imem[0] = ri(4'h5, 3'd1, 8'd3);
    imem[1] = ri(4'h5, 3'd2, 8'd1);
    imem[2] = ri(4'h5, 3'd3, 8'd0);
    imem[3] = rr(4'h0, 3'd3, 3'd3, 3'd1);
    imem[4] = rr(4'h1, 3'd1, 3'd1, 3'd2);
    imem[5] = ri(4'hB, 3'd0, 8'hFE);      // BNE zero, -2
    imem[6] = ri(4'h5, 3'd0, 8'd20);
    imem[7] = rr(4'h9, 3'd3, 3'd0, 3'd0);
    imem[8] = ri(4'hC, 3'd0, 8'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 imemAddr in reset", imemAddr, 16'h0000);
    chk("R1 dmemWe in reset", {15'b0, dmemWe}, 16'h0000);
    rstN = 1'b1;
    chk("R1 imemAddr at release", imemAddr, 16'h0000);
    @(negedge clk);
    chk("R2 fetch step 1", imemAddr, 16'h0001);
    @(negedge clk);
    chk("R2 fetch step 2", imemAddr, 16'h0002);
    repeat (40) @(negedge clk);
    chk("R7 backward branch loop sum", dmem[20], 16'h0006);

    // ---- vector table: R3 R4 R5 R7 R10 ----
    for (int v = 0; v < 9; v++) begin
      holdReset();
      clearImem();
      poke(0, VEC[v][50:35]);
      poke(1, VEC[v][34:19]);
      for (int a = 2; a < 6; a++) poke(a, 16'h5A5A);
      imem[0]  = ri(4'h5, 3'd0, 8'd0);
      imem[1]  = ri(4'h5, 3'd4, 8'd1);
      imem[2]  = rr(4'h8, 3'd1, 3'd0, 3'd0);
      imem[3]  = rr(4'h8, 3'd2, 3'd4, 3'd0);
      imem[4]  = rr(VEC[v][54:51], 3'd3, 3'd1, 3'd2);
      imem[5]  = ri(4'h5, 3'd6, 8'd0);
      imem[6]  = ri(4'h5, 3'd7, 8'd0);
      imem[7]  = ri(4'h5, 3'd5, 8'd0);
      imem[8]  = ri(4'hB, 3'd0, 8'd2);    // zero clear -> skip
      imem[9]  = ri(4'h5, 3'd6, 8'd1);
      imem[10] = ri(4'hB, 3'd1, 8'd2);    // carry clear -> skip
      imem[11] = ri(4'h5, 3'd7, 8'd1);
      imem[12] = ri(4'hB, 3'd2, 8'd2);    // parity clear -> skip
      imem[13] = ri(4'h5, 3'd5, 8'd1);
      imem[14] = ri(4'h5, 3'd0, 8'd2);
      imem[15] = rr(4'h9, 3'd3, 3'd0, 3'd0);
      imem[16] = ri(4'h5, 3'd0, 8'd3);
      imem[17] = rr(4'h9, 3'd6, 3'd0, 3'd0);
      imem[18] = ri(4'h5, 3'd0, 8'd4);
      imem[19] = rr(4'h9, 3'd7, 3'd0, 3'd0);
      imem[20] = ri(4'h5, 3'd0, 8'd5);
      imem[21] = rr(4'h9, 3'd5, 3'd0, 3'd0);
      imem[22] = ri(4'hC, 3'd0, 8'd0);
      release_();
      repeat (60) @(negedge clk);
      chk($sformatf("R3 R10 result vec%0d", v), dmem[2], VEC[v][18:3]);
      chk($sformatf("R4 zero vec%0d", v), dmem[3], {15'b0, VEC[v][2]});
      chk($sformatf("R5 carry vec%0d", v), dmem[4], {15'b0, VEC[v][1]});
      chk($sformatf("R4 parity vec%0d", v), dmem[5], {15'b0, VEC[v][0]});
    end

    // ---- directed: forwarding, flag forwarding, flush, load-use on store data ----
    holdReset();
    clearImem();
    poke(0, 16'h5555);
    poke(10, 16'h5555);
    poke(11, 16'hAAAA);
    poke(12, 16'hAAAA);
    imem[0]  = ri(4'h5, 3'd1, 8'd5);
    imem[1]  = ri(4'h5, 3'd2, 8'hFD);     // -3
    imem[2]  = rr(4'h0, 3'd3, 3'd1, 3'd2); // 2
    imem[3]  = rr(4'h0, 3'd3, 3'd3, 3'd3); // 4
    imem[4]  = rr(4'h1, 3'd4, 3'd3, 3'd3); // 0, zero set
    imem[5]  = ri(4'hA, 3'd0, 8'd3);       // BEQ zero -> 8
    imem[6]  = ri(4'h5, 3'd5, 8'd7);       // must be discarded
    imem[7]  = ri(4'h5, 3'd5, 8'd7);
    imem[8]  = ri(4'h5, 3'd0, 8'd10);
    imem[9]  = rr(4'h9, 3'd3, 3'd0, 3'd0);
    imem[10] = rr(4'h8, 3'd6, 3'd0, 3'd0);
    imem[11] = rr(4'h9, 3'd6, 3'd4, 3'd0);
    imem[12] = ri(4'h5, 3'd0, 8'd11);
    imem[13] = rr(4'h9, 3'd5, 3'd0, 3'd0);
    imem[14] = ri(4'h5, 3'd0, 8'd12);
    imem[15] = rr(4'h9, 3'd7, 3'd0, 3'd0);
    imem[16] = ri(4'hC, 3'd0, 8'd0);
    release_();
    repeat (50) @(negedge clk);
    chk("R9 forwarded chain result", dmem[10], 16'h0004);
    chk("R10 load then store of loaded reg", dmem[0], 16'h0004);
    chk("R8 discarded instruction left r5", dmem[11], 16'h0000);
    chk("R1 untouched register is zero", dmem[12], 16'h0000);
    chk("R6 no stray write", dmem[1], 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule